// File: doc/BRIEF.md
# I2C Event Status Flag Register

This block is an 8-bit status register for an I2C controller. Three event flags sit in its upper bits. The first marks a stop condition that arrives while a frame is still moving (error stop). The second marks a stop condition that arrives between frames (normal stop). The third marks that a continuous-transfer interrupt was requested.

The bus engine delivers events as single-cycle pulses. Mode and enable information arrives as input levels. A continuous-transfer event also raises the controller's master interrupt flag, which this block holds and drives out.

Software reads the register through a plain read/write port. To acknowledge a flag, software first reads it while it is 1, then writes 0 to that bit. Each read arms only the bits that were set at that moment, and the next write uses up the arm. Clearing the master interrupt flag also sweeps the event flags. The transfer flag is swept only while one of the two enable inputs is high.

Top module: `i2c_evt_status`

## Requirements
- R1: After reset, `cpu_rdata` is 8'h00 and `irq_flag` is 0.
- R2: A `stop_seen` pulse with `in_frame`=1, `slave_mode`=1 and `i2c_fmt`=1 sets bit 7 (error stop) one clock later. Outside I2C-format slave mode the pulse sets nothing.
- R3: A `stop_seen` pulse with `in_frame`=0 in I2C-format slave mode sets bit 6 (normal stop) one clock later.
- R4: Writing 0 to a set flag bit leaves it at 1 unless a read since the last write returned 1 for that bit.
- R5: Writing 0 to a bit whose arm is set clears the bit on the next clock. The arm is per bit. Any write consumes all arms, so each clear needs a fresh read.
- R6: An `irq_clr` pulse clears bits 7 and 6 unconditionally. It also clears the master interrupt flag.
- R7: `irq_clr` clears bit 5 (continuous transfer) only while `mod_en` or `ext_en` is 1.
- R8: With `i2c_fmt`=1 and `slave_mode`=0, a `buf_empty` or `buf_full` pulse sets bit 5 and `irq_flag` on the same clock. With `i2c_fmt`=0 nothing is set. `irq_flag` falls only on `irq_clr`.
- R9: With `slave_mode`=1, the bit-5 set condition additionally requires `addr_match_ext`=1.
- R10: When a set event and a clear request (software or `irq_clr`) arrive in the same cycle, the flag ends at 1. The same holds for `irq_flag`.
- R11: Writing 1 to any bit has no effect, and bits 4 to 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Register read strobe; arms bits currently at 1 |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register contents, flags in bits 7..5 |
| slave_mode | input | 1 | 1 = slave mode, 0 = other modes |
| i2c_fmt | input | 1 | 1 = I2C bus format selected |
| in_frame | input | 1 | A frame is in transfer |
| stop_seen | input | 1 | Stop condition detected (pulse) |
| buf_empty | input | 1 | Data-register-empty flag became 1 (pulse) |
| buf_full | input | 1 | Data-register-full flag became 1 (pulse) |
| addr_match_ext | input | 1 | Extended address-match level |
| mod_en | input | 1 | Module enable level |
| ext_en | input | 1 | Extended enable level |
| irq_clr | input | 1 | Clear master interrupt flag (pulse) |
| irq_flag | output | 1 | Master interrupt request flag |

## Verification
The bench builds the block with its default 8-bit register width. With that width the three flags land in bits 7, 6 and 5 and five reserved bits remain below them. This lets the bench check that writes of all ones leave the reserved field at zero. It also places every flag at the position software decodes, so the per-bit arming, the consumed arm after a write and the same-cycle set/clear races can all be observed through `cpu_rdata` alone.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int NUM_FLAGS = 3;

    typedef enum int {
        FLG_ESTOP = 0,
        FLG_NSTOP = 1,
        FLG_XFER  = 2
    } flag_id_e;

    typedef struct packed {
        logic stop_pulse;
        logic in_frame;
        logic buf_empty;
        logic buf_full;
    } bus_evt_t;

    typedef struct packed {
        logic slave;
        logic i2c_fmt;
        logic addr_ext;
    } mode_t;

    function automatic int flag_bit(input int reg_w, input int idx);
        return reg_w - 1 - idx;
    endfunction

endpackage

// File: rtl/i2c_evt_setgen.sv
module i2c_evt_setgen
    import i2c_evt_pkg::*;
(
    input  bus_evt_t               evt,
    input  mode_t                  mode,
    output logic [NUM_FLAGS-1:0]   set_o
);
    logic stop_ok;
    logic buf_evt;

    always_comb begin
        stop_ok = mode.slave & mode.i2c_fmt & evt.stop_pulse;
        buf_evt = evt.buf_empty | evt.buf_full;
        set_o = '0;
        set_o[FLG_ESTOP] = stop_ok & evt.in_frame;
        set_o[FLG_NSTOP] = stop_ok & ~evt.in_frame;
        set_o[FLG_XFER]  = mode.i2c_fmt & buf_evt & (~mode.slave | mode.addr_ext);
    end
endmodule

// File: rtl/i2c_evt_flagbit.sv
module i2c_evt_flagbit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic hw_clr_i,
    output logic flag_o
);
    logic flag_q, arm_q;
    logic sw_clr;
    logic flag_d, arm_d;

    always_comb begin
        sw_clr = wr_i & ~wbit_i & arm_q;
        if (set_i)
            flag_d = 1'b1;
        else if (sw_clr | hw_clr_i)
            flag_d = 1'b0;
        else
            flag_d = flag_q;
        if (wr_i)
            arm_d = 1'b0;
        else if (rd_i & flag_q)
            arm_d = 1'b1;
        else
            arm_d = arm_q;
        arm_d = arm_d & flag_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            arm_q  <= arm_d;
        end
    end

    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q); // R10
    AST_NO_CLR_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (flag_q && wr_i && !arm_q && !hw_clr_i) |=> flag_q); // R4
    AST_ARMED_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !wbit_i && arm_q && !set_i) |=> !flag_q); // R5
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
    import i2c_evt_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             slave_mode,
    input  logic             i2c_fmt,
    input  logic             in_frame,
    input  logic             stop_seen,
    input  logic             buf_empty,
    input  logic             buf_full,
    input  logic             addr_match_ext,
    input  logic             mod_en,
    input  logic             ext_en,
    input  logic             irq_clr,
    output logic             irq_flag
);
    localparam int LOW_W = REG_W - NUM_FLAGS;

    bus_evt_t               evt;
    mode_t                  mode;
    logic [NUM_FLAGS-1:0]   set_vec;
    logic [NUM_FLAGS-1:0]   flags;
    logic                   irq_q;
    logic                   unused_wbits;

    assign evt  = '{stop_pulse: stop_seen, in_frame: in_frame,
                    buf_empty: buf_empty, buf_full: buf_full};
    assign mode = '{slave: slave_mode, i2c_fmt: i2c_fmt, addr_ext: addr_match_ext};
    assign unused_wbits = ^cpu_wdata[LOW_W-1:0];

    i2c_evt_setgen u_setgen (
        .evt   (evt),
        .mode  (mode),
        .set_o (set_vec)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic hw_clr;
        if (i == int'(FLG_XFER)) begin : g_gated
            assign hw_clr = irq_clr & (mod_en | ext_en);
        end else begin : g_plain
            assign hw_clr = irq_clr;
        end
        i2c_evt_flagbit u_bit (
            .clk      (clk),
            .rst      (rst),
            .set_i    (set_vec[i]),
            .rd_i     (cpu_rd),
            .wr_i     (cpu_wr),
            .wbit_i   (cpu_wdata[flag_bit(REG_W, i)]),
            .hw_clr_i (hw_clr),
            .flag_o   (flags[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (set_vec[FLG_XFER])
            irq_q <= 1'b1;
        else if (irq_clr)
            irq_q <= 1'b0;
    end

    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NUM_FLAGS; i++)
            cpu_rdata[flag_bit(REG_W, i)] = flags[i];
    end

    assign irq_flag = irq_q;

    AST_IRQ_WITH_XFER: assert property (@(posedge clk) disable iff (rst)
        set_vec[FLG_XFER] |=> (irq_q && flags[FLG_XFER])); // R8
    AST_IRQ_OWN_CLR: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_clr) |=> irq_q); // R8
    AST_STOP_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
        (stop_seen && !(slave_mode && i2c_fmt) && !flags[FLG_ESTOP]) |=> !flags[FLG_ESTOP]); // R2
    AST_SLAVE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (i2c_fmt && slave_mode && !addr_match_ext && !flags[FLG_XFER] && (buf_empty || buf_full))
        |=> !flags[FLG_XFER]); // R9
    AST_XFER_CLR_GATED: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !mod_en && !ext_en && flags[FLG_XFER]) |=> flags[FLG_XFER]); // R7
endmodule

// File: tb/i2c_evt_status_test.sv
module i2c_evt_status_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_rd = 0, cpu_wr = 0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       slave_mode = 0, i2c_fmt = 1, in_frame = 0, stop_seen = 0;
    logic       buf_empty = 0, buf_full = 0, addr_match_ext = 0;
    logic       mod_en = 1, ext_en = 0, irq_clr = 0;
    logic       irq_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    i2c_evt_status uut (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .slave_mode(slave_mode), .i2c_fmt(i2c_fmt), .in_frame(in_frame),
        .stop_seen(stop_seen), .buf_empty(buf_empty), .buf_full(buf_full),
        .addr_match_ext(addr_match_ext), .mod_en(mod_en), .ext_en(ext_en),
        .irq_clr(irq_clr), .irq_flag(irq_flag)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic stop_pulse(input logic frame);
        in_frame = frame; stop_seen = 1; step(); stop_seen = 0; in_frame = 0;
    endtask

    task automatic do_read();
        cpu_rd = 1; step(); cpu_rd = 0;
    endtask

    task automatic do_write(input logic [7:0] d);
        cpu_wdata = d; cpu_wr = 1; step(); cpu_wr = 0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1; step(); irq_clr = 0;
    endtask

    task automatic pulse_empty();
        buf_empty = 1; step(); buf_empty = 0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", cpu_rdata, 8'h00);
        chk("R1 irq", {7'b0, irq_flag}, 8'h00);
    endtask

    task automatic t_stop_flags();
        slave_mode = 1; i2c_fmt = 1;
        stop_pulse(1);
        chk("R2 error stop", cpu_rdata, 8'h80);
        chk("R2 no irq", {7'b0, irq_flag}, 8'h00);
        stop_pulse(0);
        chk("R3 normal stop", cpu_rdata, 8'hC0);
        mod_en = 0;
        pulse_clr();
        chk("R6 stop flags swept", cpu_rdata, 8'h00);
        mod_en = 1;
        slave_mode = 0;
        stop_pulse(1);
        chk("R2 non-slave ignored", cpu_rdata, 8'h00);
        slave_mode = 1; i2c_fmt = 0;
        stop_pulse(0);
        chk("R2 non-I2C ignored", cpu_rdata, 8'h00);
        i2c_fmt = 1;
    endtask

    task automatic t_sw_clear();
        slave_mode = 1; i2c_fmt = 1;
        stop_pulse(1);
        do_write(8'h00);
        chk("R4 write without read", cpu_rdata, 8'h80);
        do_read();
        do_write(8'h00);
        chk("R5 armed clear", cpu_rdata, 8'h00);
        stop_pulse(1);
        do_read();
        do_write(8'hFF);
        chk("R11 write ones", cpu_rdata, 8'h80);
        do_write(8'h00);
        chk("R5 arm consumed", cpu_rdata, 8'h80);
        do_read();
        stop_pulse(0);
        do_write(8'h00);
        chk("R5 per-bit arm", cpu_rdata, 8'h40);
        do_read();
        do_write(8'h00);
        chk("R5 second clear", cpu_rdata, 8'h00);
    endtask

    task automatic t_xfer();
        slave_mode = 0; i2c_fmt = 1; mod_en = 1; ext_en = 0;
        pulse_empty();
        chk("R8 xfer flag", cpu_rdata, 8'h20);
        chk("R8 irq same cycle", {7'b0, irq_flag}, 8'h01);
        do_read();
        do_write(8'h00);
        chk("R8 irq held after sw clear", {7'b0, irq_flag}, 8'h01);
        pulse_empty();
        pulse_clr();
        chk("R6 xfer swept", cpu_rdata, 8'h00);
        chk("R6 irq cleared", {7'b0, irq_flag}, 8'h00);
        buf_full = 1; step(); buf_full = 0;
        mod_en = 0;
        pulse_clr();
        chk("R7 gated off", cpu_rdata, 8'h20);
        chk("R7 irq still cleared", {7'b0, irq_flag}, 8'h00);
        ext_en = 1;
        pulse_clr();
        chk("R7 ext enable clears", cpu_rdata, 8'h00);
        ext_en = 0; mod_en = 1;
        slave_mode = 1; addr_match_ext = 0;
        pulse_empty();
        chk("R9 no match", cpu_rdata, 8'h00);
        addr_match_ext = 1;
        buf_full = 1; step(); buf_full = 0;
        chk("R9 match", cpu_rdata, 8'h20);
        pulse_clr();
        slave_mode = 0; i2c_fmt = 0;
        pulse_empty();
        chk("R8 non-I2C format", cpu_rdata, 8'h00);
        chk("R8 non-I2C irq", {7'b0, irq_flag}, 8'h00);
        i2c_fmt = 1; addr_match_ext = 0;
    endtask

    task automatic t_races();
        slave_mode = 1; i2c_fmt = 1;
        stop_pulse(1);
        do_read();
        cpu_wdata = 8'h00; cpu_wr = 1; stop_seen = 1; in_frame = 1;
        step();
        cpu_wr = 0; stop_seen = 0; in_frame = 0;
        chk("R10 set beats sw clear", cpu_rdata, 8'h80);
        slave_mode = 0;
        irq_clr = 1; buf_empty = 1;
        step();
        irq_clr = 0; buf_empty = 0;
        chk("R10 set beats irq_clr", cpu_rdata, 8'h20);
        chk("R10 irq set wins", {7'b0, irq_flag}, 8'h01);
        do_write(8'hFF);
        chk("R11 low bits zero", cpu_rdata & 8'h1F, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst = 0;
        t_reset();
        t_stop_flags();
        t_sw_clear();
        t_xfer();
        t_races();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule